// File: doc/BRIEF.md
# Interprocessor Command Dispatcher with Startup Sequencer

The block takes a 64-bit interprocessor command word written by one processor and turns it into per-target delivery requests. A fixed-vector command raises an edge-type interrupt request that carries the command's vector. A non-maskable command raises a non-maskable request. Each selected target is served on its own clock, starting with the lowest processor ID. While the target set drains, the block holds `busy_o` high and refuses new commands.

The block also tracks a boot state for every processor. Processor 0 leaves reset already running. Every other processor leaves reset in the reset state. Only processor 0 can move another processor forward. A reset-type command moves a target into wait-for-startup. A startup command then moves the target to running and issues a start request. That request carries the target's ID and a page-aligned start address. The outer layer uses the start request to add the target to its active-processor mask.

Any command the block does not resolve by itself raises a one-cycle `unhandled_o` pulse, so that a higher layer can take it over.

Top module: `ipi_dispatch`

## Requirements
- R1: While reset is held and in the first cycle after it is released, all request bitmaps are zero, and `busy_o`, `start_req_o` and `unhandled_o` are low.
- R2: The destination is `cmd_i[63:56]` when `ext_mode_i` is 0 and `cmd_i[63:32]` when it is 1. A destination that is not below NUM_CPU selects no target and does not raise `unhandled_o`.
- R3: For fixed and non-maskable commands, the shorthand field `cmd_i[19:18]` selects the target set:
  - 0 selects the destination;
  - 1 selects the sender;
  - 2 selects every processor set in `active_i`;
  - 3 selects every processor set in `active_i` except the sender.
- R4: The delivery mode is `cmd_i[10:8]`. Mode 0 (fixed) raises `fixed_req_o` for each target, with `fixed_vec_o` equal to `cmd_i[7:0]`. Mode 4 raises `nmi_req_o` for each target.
- R5: A command is accepted on a rising edge where `cmd_valid_i` is 1 and `busy_o` is 0. After that edge, exactly one target request is high per cycle, in ascending ID order. `busy_o` stays high until the last target's cycle, and commands presented while busy are dropped.
- R6: After reset, processor 0 is in the running state and every other processor is in the reset state. A startup command sent to a processor that has not yet received a reset-type command therefore issues no start request.
- R7: A reset-type command (mode 5) with the level bit `cmd_i[14]` at 0 has no effect and does not raise `unhandled_o`.
- R8: A reset-type command with level 1, from sender 0, to a destination between 1 and NUM_CPU-1, moves that target from the reset state to wait-for-startup. It changes nothing in any other state.
- R9: A startup command (mode 6) from sender 0, to a destination between 1 and NUM_CPU-1, acts only if the target is in wait-for-startup. In that case the target becomes running, and in the cycle after acceptance `start_req_o` pulses with `start_id_o` equal to the target and `start_addr_o` equal to `cmd_i[7:0] << 12`.
- R10: `unhandled_o` pulses in the cycle after acceptance in three cases:
  - the mode is 1, 2, 3 or 7;
  - a level-1 reset-type command, or a startup command, comes from a nonzero sender;
  - a level-1 reset-type command, or a startup command, has destination 0 or a destination not below NUM_CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command write strobe |
| cmd_i | input | 64 | Command word |
| sender_i | input | ID_W | ID of the processor writing the command |
| ext_mode_i | input | 1 | Extended addressing: 32-bit destination field |
| active_i | input | NUM_CPU | Mask of active processors |
| busy_o | output | 1 | Targets still being served; new commands are dropped |
| fixed_req_o | output | NUM_CPU | One-hot fixed interrupt request |
| fixed_vec_o | output | 8 | Vector of the fixed request |
| nmi_req_o | output | NUM_CPU | One-hot non-maskable request |
| start_req_o | output | 1 | Start request pulse |
| start_id_o | output | ID_W | Processor to start |
| start_addr_o | output | 20 | Start address (vector << 12) |
| unhandled_o | output | 1 | Command left for a higher layer |

## Verification
The bench goes after the boot sequence out of order:
- A startup command before any reset-type command. A design that lets a processor start from the reset state would issue a start request here.
- A repeated startup command. A design that does not hold the running state would start the processor twice.
- A reset-type command to a processor that is already running. A design that lets the state fall back would start the processor again on a later startup command.
- A command with the level bit at 0. A design that ignores the level bit would raise the wait state.

The same destination word is read in both addressing modes, with byte values chosen so that a wrong field position sends the request to a different processor.

The broadcast shorthands are sent with sparse active masks, and a second command is presented while the first is still draining. Wrong serialization order, a lost or extra target, or a command accepted while busy would then show up in a clock-by-clock comparison with a behavioural queue model.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [1:0] {
    BOOT_RESET = 2'd0,
    BOOT_WAIT  = 2'd1,
    BOOT_RUN   = 2'd2
  } boot_e;

  localparam logic [2:0] DM_FIXED = 3'b000;
  localparam logic [2:0] DM_NMI   = 3'b100;
  localparam logic [2:0] DM_INIT  = 3'b101;
  localparam logic [2:0] DM_START = 3'b110;

  localparam logic [1:0] SH_DEST   = 2'd0;
  localparam logic [1:0] SH_SELF   = 2'd1;
  localparam logic [1:0] SH_ALL    = 2'd2;
  localparam logic [1:0] SH_OTHERS = 2'd3;

  localparam int unsigned PAGE_SHIFT = 12;
endpackage

// File: rtl/ipi_target_sel.sv
module ipi_target_sel import ipi_pkg::*; #(
  parameter int unsigned NUM_CPU = 8,
  localparam int unsigned ID_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic [1:0]         shorthand_i,
  input  logic [31:0]        dest_i,
  input  logic [ID_W-1:0]    sender_i,
  input  logic [NUM_CPU-1:0] active_i,
  output logic [NUM_CPU-1:0] mask_o
);
  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    logic is_dest, is_self;
    assign is_dest = (dest_i == 32'(g));
    assign is_self = (sender_i == ID_W'(g));
    always_comb begin
      unique case (shorthand_i)
        SH_DEST:   mask_o[g] = is_dest;
        SH_SELF:   mask_o[g] = is_self;
        SH_ALL:    mask_o[g] = active_i[g];
        default:   mask_o[g] = active_i[g] & ~is_self;
      endcase
    end
  end
endmodule

// File: rtl/ipi_boot_fsm.sv
module ipi_boot_fsm import ipi_pkg::*; #(
  parameter bit IS_BOOT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic start_i,
  output logic go_o
);
  boot_e state_q, state_d;

  assign go_o = start_i && (state_q == BOOT_WAIT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BOOT_RESET: if (init_i) state_d = BOOT_WAIT;
      BOOT_WAIT:  if (start_i) state_d = BOOT_RUN;
      default:    state_d = state_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= IS_BOOT ? BOOT_RUN : BOOT_RESET;
    else         state_q <= state_d;
  end

  AST_RUN_ONLY_FROM_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BOOT_RUN && $past(state_q) != BOOT_RUN) |-> $past(state_q) == BOOT_WAIT); // R9
  AST_RUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == BOOT_RUN) |-> state_q == BOOT_RUN); // R8
endmodule

// File: rtl/ipi_serializer.sv
module ipi_serializer #(
  parameter int unsigned NUM_CPU = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [NUM_CPU-1:0] mask_i,
  output logic               busy_o,
  output logic [NUM_CPU-1:0] grant_o
);
  logic [NUM_CPU-1:0] pend_q;

  assign busy_o  = |pend_q;
  assign grant_o = pend_q & (~pend_q + NUM_CPU'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pend_q <= '0;
    else if (load_i && !busy_o) pend_q <= mask_i;
    else                        pend_q <= pend_q & ~grant_o;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R5
  AST_DRAIN_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $countones(pend_q) == $past($countones(pend_q)) - 1); // R5
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch import ipi_pkg::*; #(
  parameter int unsigned NUM_CPU = 8,
  localparam int unsigned ID_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int unsigned VEC_W = 8,
  localparam int unsigned ADDR_W = VEC_W + PAGE_SHIFT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [63:0]        cmd_i,
  input  logic [ID_W-1:0]    sender_i,
  input  logic               ext_mode_i,
  input  logic [NUM_CPU-1:0] active_i,
  output logic               busy_o,
  output logic [NUM_CPU-1:0] fixed_req_o,
  output logic [VEC_W-1:0]   fixed_vec_o,
  output logic [NUM_CPU-1:0] nmi_req_o,
  output logic               start_req_o,
  output logic [ID_W-1:0]    start_id_o,
  output logic [ADDR_W-1:0]  start_addr_o,
  output logic               unhandled_o
);
  logic [VEC_W-1:0] vec;
  logic [2:0]       mode;
  logic [1:0]       shorthand;
  logic             level;
  logic [31:0]      dest;
  logic             unused_bits;

  assign vec         = cmd_i[VEC_W-1:0];
  assign mode        = cmd_i[10:8];
  assign level       = cmd_i[14];
  assign shorthand   = cmd_i[19:18];
  assign dest        = ext_mode_i ? cmd_i[63:32] : {24'd0, cmd_i[63:56]};
  assign unused_bits = ^{cmd_i[13:11], cmd_i[17:15], cmd_i[31:20]};

  logic accept, is_deliver, is_init, is_start, mp_ok;
  logic [ID_W-1:0] dest_idx;

  assign accept     = cmd_valid_i && !busy_o;
  assign is_deliver = (mode == DM_FIXED) || (mode == DM_NMI);
  assign is_init    = (mode == DM_INIT);
  assign is_start   = (mode == DM_START);
  assign dest_idx   = dest[ID_W-1:0];
  assign mp_ok      = (sender_i == '0) && (dest != 32'd0) && (dest < 32'(NUM_CPU));

  // target set for fixed / nmi delivery
  logic [NUM_CPU-1:0] sel_mask, load_mask, grant;

  ipi_target_sel #(.NUM_CPU(NUM_CPU)) u_sel (
    .shorthand_i (shorthand),
    .dest_i      (dest),
    .sender_i    (sender_i),
    .active_i    (active_i),
    .mask_o      (sel_mask)
  );

  assign load_mask = is_deliver ? sel_mask : '0;

  ipi_serializer #(.NUM_CPU(NUM_CPU)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .mask_i  (load_mask),
    .busy_o  (busy_o),
    .grant_o (grant)
  );

  logic nmi_q;
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q <= 1'b0;
      vec_q <= '0;
    end else if (accept && is_deliver) begin
      nmi_q <= (mode == DM_NMI);
      vec_q <= vec;
    end
  end

  assign fixed_req_o = nmi_q ? '0 : grant;
  assign nmi_req_o   = nmi_q ? grant : '0;
  assign fixed_vec_o = vec_q;

  // per-processor boot state
  logic [NUM_CPU-1:0] init_hit, start_hit, go;

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_boot
    assign init_hit[g]  = accept && is_init && level && mp_ok && (dest_idx == ID_W'(g));
    assign start_hit[g] = accept && is_start && mp_ok && (dest_idx == ID_W'(g));
    ipi_boot_fsm #(.IS_BOOT(g == 0)) u_fsm (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .init_i  (init_hit[g]),
      .start_i (start_hit[g]),
      .go_o    (go[g])
    );
  end

  logic [ID_W-1:0] go_id;
  always_comb begin
    go_id = '0;
    for (int i = 0; i < NUM_CPU; i++) if (go[i]) go_id = ID_W'(i);
  end

  logic unh_d;
  always_comb begin
    if (!accept)       unh_d = 1'b0;
    else if (is_init)  unh_d = level && !mp_ok;
    else if (is_start) unh_d = !mp_ok;
    else               unh_d = !is_deliver;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_req_o  <= 1'b0;
      start_id_o   <= '0;
      start_addr_o <= '0;
      unhandled_o  <= 1'b0;
    end else begin
      start_req_o <= |go;
      unhandled_o <= unh_d;
      if (|go) begin
        start_id_o   <= go_id;
        start_addr_o <= {vec, {PAGE_SHIFT{1'b0}}};
      end
    end
  end

  AST_START_ONLY_FROM_BOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_o |-> ($past(sender_i) == '0 && $past(cmd_valid_i))); // R9
  AST_UNH_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unhandled_o |-> $past(cmd_valid_i && !busy_o)); // R10
  AST_START_NOT_UNH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_req_o && unhandled_o)); // R10
  AST_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fixed_req_o | nmi_req_o)); // R5
endmodule

// File: tb/ipi_dispatch_tb.sv
module ipi_dispatch_tb_top;
  localparam int N = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, ext_mode = 1'b0;
  logic [63:0] cmd = '0;
  logic [2:0] sender = '0;
  logic [N-1:0] active = '0;
  logic busy, start_req, unh;
  logic [N-1:0] fixed_req, nmi_req;
  logic [7:0] fixed_vec;
  logic [2:0] start_id;
  logic [19:0] start_addr;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_dispatch #(.NUM_CPU(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .sender_i(sender), .ext_mode_i(ext_mode), .active_i(active),
    .busy_o(busy), .fixed_req_o(fixed_req), .fixed_vec_o(fixed_vec),
    .nmi_req_o(nmi_req), .start_req_o(start_req), .start_id_o(start_id),
    .start_addr_o(start_addr), .unhandled_o(unh)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int q[$];
  int boot[N];
  bit m_nmi, m_start, m_unh;
  int m_vec, m_id, m_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_nmi = 0; m_start = 0; m_unh = 0; m_vec = 0;
      for (int i = 0; i < N; i++) boot[i] = (i == 0) ? 2 : 0;
    end else begin
      bit was_busy;
      int mode, sh, dst, snd;
      bit ok;
      was_busy = (q.size() != 0);
      if (was_busy) void'(q.pop_front());
      m_start = 0; m_unh = 0;
      if (cmd_valid && !was_busy) begin
        mode = int'(cmd[10:8]); sh = int'(cmd[19:18]); snd = int'(sender);
        dst = ext_mode ? int'(cmd[63:32]) : int'(cmd[63:56]);
        ok = (snd == 0) && (dst != 0) && (dst > 0) && (dst < N);
        if (mode == 0 || mode == 4) begin
          m_nmi = (mode == 4); m_vec = int'(cmd[7:0]);
          for (int i = 0; i < N; i++) begin
            bit s;
            case (sh)
              0: s = (i == dst);
              1: s = (i == snd);
              2: s = active[i];
              default: s = active[i] && (i != snd);
            endcase
            if (s) q.push_back(i);
          end
        end else if (mode == 5) begin
          if (cmd[14]) begin
            if (!ok) m_unh = 1;
            else if (boot[dst] == 0) boot[dst] = 1;
          end
        end else if (mode == 6) begin
          if (!ok) m_unh = 1;
          else if (boot[dst] == 1) begin
            boot[dst] = 2; m_start = 1; m_id = dst; m_addr = int'(cmd[7:0]) << 12;
          end
        end else m_unh = 1;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    logic [N-1:0] ef, en;
    ef = '0; en = '0;
    if (q.size() != 0) begin
      if (m_nmi) en[q[0]] = 1'b1; else ef[q[0]] = 1'b1;
    end
    chk("R5 busy", busy, q.size() != 0);
    chk("R4 fixed_req", fixed_req, ef);
    chk("R4 nmi_req", nmi_req, en);
    if (ef != 0) chk("R4 vector", fixed_vec, m_vec);
    chk("R9 start_req", start_req, m_start);
    if (m_start) begin
      chk("R9 start_id", start_id, m_id);
      chk("R9 start_addr", start_addr, m_addr);
    end
    chk("R10 unhandled", unh, m_unh);
  end

  function automatic logic [63:0] mk(int mode, int sh, bit lvl, int vec, int dst, bit ext);
    logic [63:0] c = '0;
    c[7:0] = vec[7:0]; c[10:8] = mode[2:0]; c[14] = lvl; c[19:18] = sh[1:0];
    if (ext) c[63:32] = dst[31:0]; else c[63:56] = dst[7:0];
    return c;
  endfunction

  task automatic send(logic [63:0] c, int snd, bit ext, logic [N-1:0] act);
    @(negedge clk);
    cmd = c; sender = snd[2:0]; ext_mode = ext; active = act; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    chk("R1 busy in reset", busy, 0);
    chk("R1 fixed in reset", fixed_req, 0);
    chk("R1 start in reset", start_req, 0);
    chk("R1 unh in reset", unh, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 nmi after reset", nmi_req, 0);

    // R6: startup before any reset-type command
    send(mk(6, 0, 1, 'h10, 3, 0), 0, 0, 8'h01);
    chk("R6 no start from reset state", start_req, 0);
    // R7: level 0 ignored
    send(mk(5, 0, 0, 0, 3, 0), 0, 0, 8'h01);
    chk("R7 level0 not unhandled", unh, 0);
    send(mk(6, 0, 1, 'h11, 3, 0), 0, 0, 8'h01);
    chk("R7 still no start", start_req, 0);
    // R10: reset-type command from nonzero sender
    send(mk(5, 0, 1, 0, 3, 0), 2, 0, 8'h07);
    chk("R10 init from sender2", unh, 1);
    // R8/R9 proper sequence
    send(mk(5, 0, 1, 0, 3, 0), 0, 0, 8'h01);
    chk("R8 init accepted quietly", unh, 0);
    send(mk(6, 0, 1, 'h9A, 3, 0), 0, 0, 8'h01);
    chk("R9 start pulse", start_req, 1);
    chk("R9 start id", start_id, 3);
    chk("R9 start addr", start_addr, 20'h9A000);
    @(negedge clk);
    chk("R9 start one cycle", start_req, 0);
    send(mk(6, 0, 1, 'h9B, 3, 0), 0, 0, 8'h09);
    chk("R9 repeat start ignored", start_req, 0);
    send(mk(5, 0, 1, 0, 3, 0), 0, 0, 8'h09);
    send(mk(6, 0, 1, 'h9C, 3, 0), 0, 0, 8'h09);
    chk("R8 init on running no effect", start_req, 0);
    // extended destination for boot
    send(mk(5, 0, 1, 0, 5, 1), 0, 1, 8'h09);
    send(mk(6, 0, 1, 'h01, 5, 1), 0, 1, 8'h09);
    chk("R2 ext start id", start_id, 5);

    // R4/R2 fixed to destination
    send(mk(0, 0, 0, 'h41, 5, 0), 1, 0, 8'hFF);
    chk("R4 fixed dest5", fixed_req, 8'h20);
    chk("R4 vector", fixed_vec, 8'h41);
    idle();
    // ext: 0x106 out of range; legacy read of same word would be cpu 0
    send(mk(0, 0, 0, 'h42, 'h106, 1), 1, 1, 8'hFF);
    chk("R2 ext out of range dropped", busy, 0);
    chk("R2 no unhandled", unh, 0);
    send(mk(0, 0, 0, 'h43, 6, 1), 1, 1, 8'hFF);
    chk("R2 ext dest6", fixed_req, 8'h40);
    idle();
    send(mk(4, 0, 0, 0, 9, 0), 1, 0, 8'hFF);
    chk("R2 legacy dest9 dropped", nmi_req, 0);

    // R3/R5 broadcast NMI with sparse mask, second cmd while busy
    send(mk(4, 2, 0, 0, 0, 0), 3, 0, 8'hA5);
    chk("R3 all first target", nmi_req, 8'h01);
    @(negedge clk);
    cmd = mk(0, 1, 0, 'h55, 0, 0); sender = 3'd6; cmd_valid = 1'b1;
    @(negedge clk);
    chk("R5 third target", nmi_req, 8'h20);
    cmd_valid = 1'b0;
    idle();
    chk("R5 busy cmd dropped", fixed_req, 0);
    send(mk(0, 3, 0, 'h77, 0, 0), 2, 0, 8'h0F);
    chk("R3 others first", fixed_req, 8'h01);
    idle();
    send(mk(0, 1, 0, 'h66, 0, 0), 4, 0, 8'h00);
    chk("R3 self", fixed_req, 8'h10);
    idle();

    // R10 other unhandled cases
    send(mk(3, 0, 0, 0, 1, 0), 0, 0, 8'h01);
    chk("R10 reserved mode", unh, 1);
    send(mk(6, 0, 1, 'h20, 4, 0), 1, 0, 8'h01);
    chk("R10 start from sender1", unh, 1);
    send(mk(5, 0, 1, 0, 0, 0), 0, 0, 8'h01);
    chk("R10 init dest0", unh, 1);
    send(mk(6, 0, 1, 0, 8, 0), 0, 0, 8'h01);
    chk("R10 start dest8", unh, 1);
    repeat (3) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule